// File: doc/BRIEF.md
# Read return queue controller

This block sits between an internal bus that returns read data and a bus-side initiator that collects it. Returned words, 64 bits each, enter an eight-entry queue together with a flag that says whether the internal read of that word was target-aborted. Aborted words are never stored. The drain side presents the stored data to the initiator one beat at a time. It uses a ready/valid handshake in which a low ready is an initiator wait state. Each beat is either the full word or one 32-bit half, depending on whether the initiator asked for a wide transfer.

Draining may start as soon as the first word arrives, so it overlaps filling. The beat that takes the last word held, with no new word arriving in that cycle, is flagged as a disconnect. If the first word of an internal read is aborted, no data ever arrives for it. The block then produces a single data-less termination beat: a target abort when the configuration enable is set, a disconnect when it is clear. When the initiator completes its transfer, or a flush is requested, everything still unread is discarded.

Top module: `rdret_queue`

## Requirements
- R1: After reset `drn_valid` is 0 and `fill_ready` is 1.
- R2: Stored words reach the initiator in fill order, and draining proceeds while filling is still under way.
- R3: A fill word with `fill_abort`=1 and `fill_first`=0 is accepted but never stored or returned; the words around it keep their order.
- R4: With `drn_wide`=1 each beat carries one whole 64-bit word on `drn_data`.
- R5: With `drn_wide`=0 each word gives two beats: bits 31:0 first, then bits 63:32, each placed in `drn_data[31:0]` with `drn_data[63:32]`=0. The queue advances only after the second beat.
- R6: While `drn_valid`=1 and `drn_ready`=0, the presented beat (data and both termination flags) stays unchanged, and no disconnect is raised because of the wait.
- R7: A fill with `fill_abort`=1 and `fill_first`=1 yields one beat with `drn_data`=0. In that beat `drn_tabort`=1 and `drn_disc`=0 when `cfg_tabort_en`=1, and `drn_tabort`=0 and `drn_disc`=1 when it is 0. The two flags are never both 1.
- R8: `drn_disc`=1 marks the beat that consumes the last stored word when no new word is written in the cycle it is loaded; other data beats have `drn_disc`=0.
- R9: A fill is held off, not lost, while the queue holds eight words (`fill_ready`=0). With the initiator stalled in wide mode, exactly nine words are taken: eight stored and one presented.
- R10: A cycle with `drn_done`=1 or `flush`=1 discards the queue, the presented beat and any pending termination. `drn_valid` is 0 on the next cycle, and a beat shown in that cycle does not count as transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | Internal bus offers a returned word |
| fill_ready | output | 1 | Queue can take a word this cycle |
| fill_data | input | 64 | Returned read word |
| fill_abort | input | 1 | Internal read of this word was target-aborted |
| fill_first | input | 1 | Word is the first of its internal read |
| cfg_tabort_en | input | 1 | Terminate a first-word abort with target abort (1) or disconnect (0) |
| flush | input | 1 | Discard all queued and presented data |
| drn_wide | input | 1 | Initiator requested a 64-bit transfer |
| drn_ready | input | 1 | Initiator takes the beat (0 = wait state) |
| drn_done | input | 1 | Initiator completed its transfer; unread data dropped |
| drn_valid | output | 1 | A beat is presented |
| drn_data | output | 64 | Beat data (32-bit beats in bits 31:0) |
| drn_disc | output | 1 | Beat ends the transfer with a disconnect |
| drn_tabort | output | 1 | Beat is a target-abort termination |

## Verification
The hardest situation to reach is a full queue while the initiator holds wait states, with the fill still pushing. That is the only point where the eight stored words plus the one presented beat can be seen, and where a word could be lost. The stimulus holds `drn_ready` low and keeps `fill_valid` high for longer than the queue can absorb, then releases the initiator while the fill continues. Disconnect placement is pinned down by directed runs, with the queue preloaded and with fills spaced so that the queue empties after every word. Long random runs in both widths, with interleaved aborted words, then compare the full beat stream against the stored fill order.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
  typedef enum logic [1:0] {
    TERM_NONE   = 2'd0,
    TERM_DISC   = 2'd1,
    TERM_TABORT = 2'd2
  } term_e;
endpackage

// File: rtl/rdq_ram.sv
module rdq_ram #(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rdq_ptrs.sv
module rdq_ptrs #(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      waddr <= '0;
      raddr <= '0;
      count <= '0;
    end else begin
      if (push) waddr <= step(waddr);
      if (pop)  raddr <= step(raddr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/rdq_drain.sv
module rdq_drain
  import rdq_pkg::*;
#(
  parameter int DW  = 64,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wide,
  input  logic          ready,
  input  logic [DW-1:0] head,
  input  logic          avail,
  input  logic          last_word,
  input  logic          push,
  input  logic          term_pend,
  input  logic          tabort_en,
  output logic          pop,
  output logic          term_take,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_disc,
  output logic          out_tabort
);
  logic  half_q;
  logic  load;
  logic  use_wide;
  term_e term_q;
  term_e term_sel;

  assign load     = !out_valid || ready;
  assign use_wide = wide && !half_q;
  assign term_sel = tabort_en ? TERM_TABORT : TERM_DISC;

  always_comb begin
    pop       = 1'b0;
    term_take = 1'b0;
    if (!clr && load) begin
      if (avail)          pop       = use_wide || half_q;
      else if (term_pend) term_take = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      half_q    <= 1'b0;
      term_q    <= TERM_NONE;
    end else if (load) begin
      if (avail) begin
        out_valid <= 1'b1;
        if (use_wide)    out_data <= head;
        else if (half_q) out_data <= {{HW{1'b0}}, head[DW-1:HW]};
        else             out_data <= {{HW{1'b0}}, head[HW-1:0]};
        half_q <= !use_wide && !half_q;
        term_q <= (pop && last_word && !push) ? TERM_DISC : TERM_NONE;
      end else if (term_pend) begin
        out_valid <= 1'b1;
        out_data  <= '0;
        term_q    <= term_sel;
      end else begin
        out_valid <= 1'b0;
        term_q    <= TERM_NONE;
      end
    end
  end

  assign out_disc   = out_valid && (term_q == TERM_DISC);
  assign out_tabort = out_valid && (term_q == TERM_TABORT);
endmodule

// File: rtl/rdret_queue.sv
module rdret_queue #(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill_valid,
  output logic          fill_ready,
  input  logic [DW-1:0] fill_data,
  input  logic          fill_abort,
  input  logic          fill_first,
  input  logic          cfg_tabort_en,
  input  logic          flush,
  input  logic          drn_wide,
  input  logic          drn_ready,
  input  logic          drn_done,
  output logic          drn_valid,
  output logic [DW-1:0] drn_data,
  output logic          drn_disc,
  output logic          drn_tabort
);
  logic          clr;
  logic          push;
  logic          pop;
  logic          full;
  logic          empty;
  logic [CW-1:0] occ;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [DW-1:0] head;
  logic          term_pend;
  logic          term_take;
  logic          fill_take;

  assign clr        = flush || drn_done;
  assign fill_ready = !full;
  assign fill_take  = fill_valid && !full;
  assign push       = fill_take && !fill_abort && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)                           term_pend <= 1'b0;
    else if (fill_take && fill_abort && fill_first) term_pend <= 1'b1;
    else if (term_take)                       term_pend <= 1'b0;
  end

  rdq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .clr(clr), .push(push), .pop(pop),
    .waddr(waddr), .raddr(raddr), .count(occ), .full(full), .empty(empty)
  );

  rdq_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(push), .waddr(waddr), .wdata(fill_data),
    .raddr(raddr), .rdata(head)
  );

  rdq_drain #(.DW(DW)) u_drain (
    .clk(clk), .rst(rst), .clr(clr), .wide(drn_wide), .ready(drn_ready),
    .head(head), .avail(!empty), .last_word(occ == CW'(1)), .push(push),
    .term_pend(term_pend), .tabort_en(cfg_tabort_en),
    .pop(pop), .term_take(term_take),
    .out_valid(drn_valid), .out_data(drn_data),
    .out_disc(drn_disc), .out_tabort(drn_tabort)
  );
endmodule

// File: rtl/rdret_queue_chk.sv
module rdret_queue_chk #(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          drn_done,
  input logic          drn_ready,
  input logic          drn_valid,
  input logic [DW-1:0] drn_data,
  input logic          drn_disc,
  input logic          drn_tabort,
  input logic          fill_ready,
  input logic [CW-1:0] occ
);
  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !drn_valid);

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (drn_valid && !drn_ready && !flush && !drn_done) |=>
      (drn_valid && $stable(drn_data) && $stable(drn_disc) && $stable(drn_tabort)));

  assert_discard_R10: assert property (@(posedge clk) disable iff (rst)
    (flush || drn_done) |=> !drn_valid);

  assert_term_excl_R7: assert property (@(posedge clk) disable iff (rst)
    drn_valid |-> !(drn_disc && drn_tabort));

  assert_tabort_nodata_R7: assert property (@(posedge clk) disable iff (rst)
    (drn_valid && drn_tabort) |-> (drn_data == '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (occ <= CW'(DEPTH)) && ((occ == CW'(DEPTH)) -> !fill_ready));
endmodule

bind rdret_queue rdret_queue_chk u_chk (
  .clk(clk), .rst(rst), .flush(flush), .drn_done(drn_done),
  .drn_ready(drn_ready), .drn_valid(drn_valid), .drn_data(drn_data),
  .drn_disc(drn_disc), .drn_tabort(drn_tabort), .fill_ready(fill_ready),
  .occ(occ)
);

// File: tb/rdret_queue_bench.sv
`timescale 1ns/1ps
module rdret_queue_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [63:0] fill_data = '0;
  logic        fill_abort = 1'b0;
  logic        fill_first = 1'b0;
  logic        cfg_tabort_en = 1'b0;
  logic        flush = 1'b0;
  logic        drn_wide = 1'b1;
  logic        drn_ready = 1'b0;
  logic        drn_done = 1'b0;
  logic        drn_valid;
  logic [63:0] drn_data;
  logic        drn_disc;
  logic        drn_tabort;

  int n_checks = 0;
  int n_err    = 0;
  logic [63:0] flog [4096];
  logic [63:0] bdata [4096];
  logic        bdisc [4096];
  logic        btab  [4096];
  int nf = 0;
  int nb = 0;

  always #4 clk = ~clk;

  rdret_queue u_rdret_queue (
    .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_data(fill_data), .fill_abort(fill_abort), .fill_first(fill_first),
    .cfg_tabort_en(cfg_tabort_en), .flush(flush), .drn_wide(drn_wide),
    .drn_ready(drn_ready), .drn_done(drn_done), .drn_valid(drn_valid),
    .drn_data(drn_data), .drn_disc(drn_disc), .drn_tabort(drn_tabort)
  );

  // Log what the next rising edge will transfer, sampled mid-cycle.
  always @(negedge clk) begin
    #1;
    if (!rst && !flush && !drn_done) begin
      if (fill_valid && fill_ready && !fill_abort && nf < 4096) begin
        flog[nf] = fill_data;
        nf++;
      end
      if (drn_valid && drn_ready && nb < 4096) begin
        bdata[nb] = drn_data;
        bdisc[nb] = drn_disc;
        btab[nb]  = drn_tabort;
        nb++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fill_valid = 0; fill_abort = 0; fill_first = 0;
    flush = 0; drn_done = 0; drn_ready = 0;
    cyc(3);
    rst = 1'b0;
    nf = 0; nb = 0;
  endtask

  task automatic send(input logic [63:0] d, input bit ab, input bit fst);
    fill_valid = 1'b1; fill_data = d; fill_abort = ab; fill_first = fst;
    #1;
    while (!fill_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    fill_valid = 1'b0; fill_abort = 1'b0; fill_first = 1'b0;
  endtask

  function automatic logic [63:0] exp_beat(input int i, input bit wide);
    if (wide) return flog[i];
    if (i % 2 == 0) return {32'h0, flog[i/2][31:0]};
    return {32'h0, flog[i/2][63:32]};
  endfunction

  task automatic check_stream(input bit wide, input string req);
    int expn;
    expn = wide ? nf : 2 * nf;
    chk(nb == expn, {req, " beat count"}, 64'(nb), 64'(expn));
    for (int i = 0; i < nb && i < expn; i++)
      chk(bdata[i] == exp_beat(i, wide) && !btab[i], req, bdata[i], exp_beat(i, wide));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));

    // R1 reset state
    do_reset();
    #1;
    chk(drn_valid == 1'b0, "R1 drn_valid", 64'(drn_valid), 64'd0);
    chk(fill_ready == 1'b1, "R1 fill_ready", 64'(fill_ready), 64'd1);

    // R4 R6 R8 wide, preloaded, wait states
    drn_wide = 1'b1;
    send(64'hA0A0_0000_0000_000A, 0, 1);
    send(64'hB0B0_0000_0000_000B, 0, 0);
    send(64'hC0C0_0000_0000_000C, 0, 0);
    cyc(2); #1;
    chk(drn_valid && drn_data == 64'hA0A0_0000_0000_000A && !drn_disc,
        "R6 first beat held", drn_data, 64'hA0A0_0000_0000_000A);
    cyc(4); #1;
    chk(drn_valid && drn_data == 64'hA0A0_0000_0000_000A && !drn_disc && !drn_tabort,
        "R6 beat stable under wait", drn_data, 64'hA0A0_0000_0000_000A);
    drn_ready = 1'b1;
    cyc(10);
    drn_ready = 1'b0;
    check_stream(1'b1, "R4 wide stream");
    chk(nb == 3 && !bdisc[0] && !bdisc[1] && bdisc[2], "R8 disconnect on last",
        {61'd0, bdisc[0], bdisc[1], bdisc[2]}, 64'd1);

    // R5 narrow halves
    do_reset();
    drn_wide = 1'b0;
    send(64'h1111_2222_3333_4444, 0, 1);
    send(64'h5555_6666_7777_8888, 0, 0);
    drn_ready = 1'b1;
    cyc(10);
    check_stream(1'b0, "R5 narrow stream");
    chk(nb == 4 && !bdisc[0] && !bdisc[1] && !bdisc[2] && bdisc[3], "R8 R5 disconnect on last half",
        {60'd0, bdisc[0], bdisc[1], bdisc[2], bdisc[3]}, 64'd1);

    // R3 aborted non-first word dropped
    do_reset();
    drn_wide = 1'b1; drn_ready = 1'b1;
    send(64'h0000_0000_0000_0D00, 0, 1);
    send(64'hDEAD_DEAD_DEAD_DEAD, 1, 0);
    send(64'h0000_0000_0000_0D02, 0, 0);
    cyc(8);
    chk(nb == 2 && bdata[1] == 64'h0000_0000_0000_0D02, "R3 aborted word skipped",
        bdata[1], 64'h0000_0000_0000_0D02);
    check_stream(1'b1, "R3 stream");

    // R7 first-word abort, enable set
    do_reset();
    cfg_tabort_en = 1'b1; drn_ready = 1'b1;
    send(64'hFFFF_0000_FFFF_0000, 1, 1);
    cyc(5);
    chk(nb == 1 && btab[0] && !bdisc[0] && bdata[0] == 64'h0, "R7 target abort beat",
        {62'd0, btab[0], bdisc[0]}, 64'd2);

    // R7 first-word abort, enable clear
    do_reset();
    cfg_tabort_en = 1'b0; drn_ready = 1'b1;
    send(64'hFFFF_0000_FFFF_0000, 1, 1);
    cyc(5);
    chk(nb == 1 && !btab[0] && bdisc[0] && bdata[0] == 64'h0, "R7 disconnect beat",
        {62'd0, btab[0], bdisc[0]}, 64'd1);

    // R9 full queue with stalled initiator
    do_reset();
    drn_wide = 1'b1; drn_ready = 1'b0;
    repeat (20) begin
      @(negedge clk);
      fill_valid = 1'b1; fill_data = 64'h100 + 64'(nf);
    end
    #1;
    chk(fill_ready == 1'b0, "R9 fill held off", 64'(fill_ready), 64'd0);
    chk(nf == 9, "R9 words taken", 64'(nf), 64'd9);
    drn_ready = 1'b1;
    forever begin
      @(negedge clk);
      if (nf >= 10) begin
        fill_valid = 1'b0;
        break;
      end
      fill_valid = 1'b1; fill_data = 64'h100 + 64'(nf);
    end
    cyc(20);
    check_stream(1'b1, "R9 no loss");
    chk(nb == 10 && bdisc[9], "R9 R8 final disconnect", 64'(bdisc[9]), 64'd1);

    // R10 initiator done discards
    do_reset();
    drn_wide = 1'b1; drn_ready = 1'b0;
    for (int i = 0; i < 4; i++) send(64'h200 + 64'(i), 0, i == 0);
    cyc(1);
    drn_done = 1'b1;
    @(negedge clk);
    drn_done = 1'b0;
    #1;
    chk(drn_valid == 1'b0, "R10 done clears beat", 64'(drn_valid), 64'd0);
    drn_ready = 1'b1;
    cyc(10);
    chk(nb == 0, "R10 nothing left after done", 64'(nb), 64'd0);
    send(64'h0000_0000_0000_0333, 0, 1);
    cyc(6);
    chk(nb == 1 && bdata[0] == 64'h333, "R10 fresh word after done", bdata[0], 64'h333);
    drn_ready = 1'b0;
    for (int i = 0; i < 3; i++) send(64'h400 + 64'(i), 0, i == 0);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    drn_ready = 1'b1;
    cyc(10);
    chk(nb == 1, "R10 flush discards", 64'(nb), 64'd1);

    // R2 R8 overlap, queue empties after every word
    do_reset();
    drn_wide = 1'b1; drn_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      send(64'h500 + 64'(i), 0, i == 0);
      cyc(2);
    end
    cyc(6);
    check_stream(1'b1, "R2 spaced stream");
    for (int i = 0; i < nb; i++)
      chk(bdisc[i], "R8 disconnect when empty", 64'(bdisc[i]), 64'd1);

    // R2 R3 R4 R5 R6 random rounds
    for (int r = 0; r < 4; r++) begin
      do_reset();
      drn_wide = r[0];
      repeat (1500) begin
        @(negedge clk);
        fill_valid = ($urandom % 2) == 0;
        fill_data  = {$urandom, $urandom};
        fill_abort = ($urandom % 10) == 0;
        fill_first = 1'b0;
        drn_ready  = ($urandom % 10) < 7;
      end
      @(negedge clk);
      fill_valid = 1'b0; fill_abort = 1'b0; drn_ready = 1'b1;
      cyc(40);
      check_stream(drn_wide, "R2 random stream");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule